// File: doc/BRIEF.md
# Selectable-Resolution Timer PWM Generator

This block turns a free-running timer into a single pulse-width modulated output. A prescaler divides the system clock by a power of two. The divisor is set by a 3-bit rate field and a fast-mode flag. The divided tick advances an 8-bit counter. The counter's period is 256, 64, 32 or 16 ticks, depending on how many low bits a resolution select treats as the period. At each period boundary the output goes high. It goes low again once the counter's low bits reach a duty value that software has written, so duty is set in steps of one tick.

The duty value can only be written, never read back. A write goes first into a holding register and takes effect at the next period boundary, so a running waveform never shows a shortened or doubled pulse. The block also gives out a one-cycle pulse at every period boundary, which surrounding logic can use as a period tick. A second channel is simply another instance.

Top module: `tpwm_gen`

## Requirements
- R1: While synchronous reset is high, the next clock edge leaves `pwm_out` and `ovf_pulse` low, and clears the prescaler, counter, holding register and active duty value.
- R2: While enabled, the counter advances once every 2^(10-`rate`) clocks when `fast` is 0, and once every 2^(7-`rate`) clocks when `fast` is 1. With `fast`=1 and `rate`=7 it advances on every clock.
- R3: `res_sel` picks the period N: 0 gives 256, 1 gives 64, 2 gives 32, 3 gives 16. A wrap happens when the counter's low log2(N) bits roll over from all ones. `ovf_pulse` is high for exactly one clock per wrap, so consecutive pulses are N times the divisor apart.
- R4: `pwm_out` goes high only on a wrap, in the same cycle that `ovf_pulse` is high.
- R5: `pwm_out` goes low when the counter's low log2(N) bits equal the low log2(N) bits of the active duty value. The high time per period is therefore (duty mod N) × divisor clocks.
- R6: A duty value whose low log2(N) bits are zero keeps `pwm_out` low all the time. When a wrap and a compare match fall on the same edge, clearing the output wins.
- R7: After enable is first raised following reset, `pwm_out` stays low through the whole first period. It first rises at the first wrap, N × divisor clocks after enable.
- R8: A write to the duty value (`duty_we` high, data on `duty_wdata`) has no effect on the period in progress. It becomes the active compare value at the next wrap.
- R9: While `en` is low, the prescaler is held at zero, the counter holds its value, `ovf_pulse` stays low and `pwm_out` is forced low. When `en` returns, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable for prescaler, counter and output |
| rate | input | 3 | Prescale rate field |
| fast | input | 1 | Fast prescale mode select |
| res_sel | input | 2 | Period resolution select (0: 256, 1: 64, 2: 32, 3: 16) |
| duty_we | input | 1 | Write strobe for the duty value |
| duty_wdata | input | 8 | Duty value to write |
| pwm_out | output | 1 | PWM output level |
| ovf_pulse | output | 1 | One-clock pulse at each counter wrap |

## Verification
The assertions assume that `res_sel` and the rate settings do not change while the block is running, and that reset is applied before the block is used. Under that assumption every period is at least sixteen ticks long and wrap pulses can never sit next to each other. The bench follows this: it changes the configuration only while reset is held, before enable is raised, and then measures whole periods between wrap pulses. Duty writes are the only input it changes while the block runs, and it times them against the observed wrap pulse.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    localparam int CNT_W   = 8;
    localparam int RES_N   = 4;
    localparam int RSEL_W  = $clog2(RES_N);

    typedef enum logic [RSEL_W-1:0] {
        RES_256 = 2'd0,
        RES_64  = 2'd1,
        RES_32  = 2'd2,
        RES_16  = 2'd3
    } res_e;

    function automatic int res_bits(input logic [RSEL_W-1:0] sel);
        int w;
        case (res_e'(sel))
            RES_256: w = 8;
            RES_64:  w = 6;
            RES_32:  w = 5;
            default: w = 4;
        endcase
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] res_mask(input logic [RSEL_W-1:0] sel);
        return CNT_W'((1 << res_bits(sel)) - 1);
    endfunction

endpackage

// File: rtl/tpwm_prescale.sv
module tpwm_prescale #(
    parameter int PRESC_W  = 10,
    parameter int RATE_W   = 3,
    parameter int NORM_TOP = 10,
    parameter int FAST_TOP = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    input  logic              fast,
    output logic              tick
);

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } presc_s;

    presc_s             st_d, st_q;
    logic [PRESC_W-1:0] limit;

    always_comb begin
        int e;
        e = fast ? (FAST_TOP - int'(rate)) : (NORM_TOP - int'(rate));
        if (e < 0) e = 0;
        if (e > PRESC_W) e = PRESC_W;
        limit = PRESC_W'((1 << e) - 1);

        tick = en && (st_q.cnt == limit);
        st_d = st_q;
        if (!en || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R9: the divider restarts from zero after any disabled cycle
    assert_prescale_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.cnt == '0));

    // R2: a tick always starts a fresh division interval
    assert_tick_restart_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (st_q.cnt == '0));

endmodule

// File: rtl/tpwm_count.sv
module tpwm_count
    import tpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RSEL_W-1:0] res_sel,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic [CNT_W-1:0]  mask,
    output logic              wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } count_s;

    count_s           st_d, st_q;
    logic [RES_N-1:0] lane_full;

    for (genvar g = 0; g < RES_N; g++) begin : g_lane
        localparam logic [CNT_W-1:0] LaneMask = res_mask(RSEL_W'(g));
        assign lane_full[g] = ((st_q.cnt & LaneMask) == LaneMask);
    end

    always_comb begin
        st_d     = st_q;
        if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        cnt_nxt  = st_d.cnt;
        mask     = res_mask(res_sel);
        wrap     = tick && lane_full[res_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: each tick moves the counter forward by exactly one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R9: without a tick the counter value is frozen
    assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q.cnt));

endmodule

// File: rtl/tpwm_outstage.sv
module tpwm_outstage
    import tpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] mask,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic             pwm_q,
    output logic             ovf_q
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
        logic             pwm;
        logic             ovf;
    } out_s;

    out_s             st_d, st_q;
    logic [CNT_W-1:0] eff;
    logic             match;

    always_comb begin
        st_d = st_q;
        if (duty_we) st_d.shadow = duty_wdata;

        eff         = wrap ? st_q.shadow : st_q.active;
        st_d.active = eff;
        match       = tick && (((cnt_nxt ^ eff) & mask) == '0);

        if (!en)       st_d.pwm = 1'b0;
        else if (match) st_d.pwm = 1'b0;
        else if (wrap)  st_d.pwm = 1'b1;

        st_d.ovf = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pwm_q = st_q.pwm;
    assign ovf_q = st_q.ovf;

    // R6: a zero compare value loaded at wrap leaves the output low
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (wrap && ((st_q.shadow & mask) == '0)) |=> !pwm_q);

    // R4: the output rises only together with the wrap pulse
    assert_rise_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> ovf_q);

    // R9: disabling forces the output low on the next edge
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm_q && !ovf_q));

    // R8: the active compare value only changes at a wrap
    assert_active_on_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(st_q.active));

endmodule

// File: rtl/tpwm_gen.sv
module tpwm_gen
    import tpwm_pkg::*;
#(
    parameter int PRESC_W = 10,
    parameter int RATE_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    input  logic              fast,
    input  logic [1:0]        res_sel,
    input  logic              duty_we,
    input  logic [7:0]        duty_wdata,
    output logic              pwm_out,
    output logic              ovf_pulse
);

    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] mask;

    tpwm_prescale #(
        .PRESC_W (PRESC_W),
        .RATE_W  (RATE_W)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .rate (rate),
        .fast (fast),
        .tick (tick)
    );

    tpwm_count u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .res_sel (res_sel),
        .cnt_nxt (cnt_nxt),
        .mask    (mask),
        .wrap    (wrap)
    );

    tpwm_outstage u_out (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (tick),
        .wrap       (wrap),
        .cnt_nxt    (cnt_nxt),
        .mask       (mask),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .pwm_q      (pwm_out),
        .ovf_q      (ovf_pulse)
    );

    // R1: reset leaves both outputs low
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!pwm_out && !ovf_pulse));

    // R3: a wrap pulse never lasts more than one clock
    assert_ovf_single_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse);

endmodule

// File: tb/tpwm_gen_test.sv
`timescale 1ns/1ps
module tpwm_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [2:0] rate = 3'd0;
    logic       fast = 1'b0;
    logic [1:0] res_sel = 2'd0;
    logic       duty_we = 1'b0;
    logic [7:0] duty_wdata = 8'd0;
    logic       pwm_out;
    logic       ovf_pulse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    tpwm_gen uut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .rate       (rate),
        .fast       (fast),
        .res_sel    (res_sel),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .pwm_out    (pwm_out),
        .ovf_pulse  (ovf_pulse)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nmod(input logic [1:0] s);
        case (s)
            2'd0:    return 256;
            2'd1:    return 64;
            2'd2:    return 32;
            default: return 16;
        endcase
    endfunction

    function automatic int divof(input logic f, input logic [2:0] r);
        return f ? (1 << (7 - int'(r))) : (1 << (10 - int'(r)));
    endfunction

    task automatic setup(input logic f, input logic [2:0] r, input logic [1:0] s);
        @(negedge clk);
        rst = 1'b1; en = 1'b0; duty_we = 1'b0;
        fast = f; rate = r; res_sel = s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_duty(input logic [7:0] v);
        @(negedge clk);
        duty_we = 1'b1; duty_wdata = v;
        @(negedge clk);
        duty_we = 1'b0;
    endtask

    task automatic sync_ovf();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ovf_pulse && n < 40000);
        if (n >= 40000) check(1'b0, "sync timeout", n, 0);
    endtask

    // starts on a sample with ovf_pulse high, ends on the next such sample
    task automatic measure(output int per, output int hi);
        per = 1;
        hi  = pwm_out ? 1 : 0;
        while (per < 40000) begin
            @(negedge clk);
            duty_we = 1'b0;
            if (ovf_pulse) break;
            if (pwm_out) hi++;
            per++;
        end
    endtask

    task automatic t_reset();
        setup(1'b1, 3'd7, 2'd3);
        check(!pwm_out, "R1 reset pwm_out", int'(pwm_out), 0);
        check(!ovf_pulse, "R1 reset ovf_pulse", int'(ovf_pulse), 0);
    endtask

    task automatic t_first_period();
        int idx = 0;
        setup(1'b1, 3'd5, 2'd3);
        write_duty(8'd5);
        en = 1'b1;
        while (!pwm_out && idx < 1000) begin
            @(negedge clk);
            idx++;
        end
        check(idx == 64, "R7 first rise after enable", idx, 64);
        check(ovf_pulse, "R4 rise coincides with wrap pulse", int'(ovf_pulse), 1);
    endtask

    task automatic t_duty(input logic f, input logic [2:0] r, input logic [1:0] s,
                          input logic [7:0] d);
        int per, hi, n, dv;
        n  = nmod(s);
        dv = divof(f, r);
        setup(f, r, s);
        write_duty(d);
        en = 1'b1;
        sync_ovf();
        measure(per, hi);
        check(per == n * dv, "R3 period length", per, n * dv);
        check(hi == (int'(d) % n) * dv, "R5 high time", hi, (int'(d) % n) * dv);
    endtask

    task automatic t_prescale(input logic f, input logic [2:0] r);
        int per, hi;
        setup(f, r, 2'd3);
        write_duty(8'd3);
        en = 1'b1;
        sync_ovf();
        measure(per, hi);
        check(per == 16 * divof(f, r), "R2 divided period", per, 16 * divof(f, r));
    endtask

    task automatic t_zero_duty(input logic [1:0] s, input logic [7:0] d);
        int per, hi, tot;
        tot = 0;
        setup(1'b1, 3'd7, s);
        write_duty(d);
        en = 1'b1;
        sync_ovf();
        for (int k = 0; k < 3; k++) begin
            measure(per, hi);
            tot += hi;
        end
        check(tot == 0, "R6 zero duty stays low", tot, 0);
    endtask

    task automatic t_shadow();
        int per, hi;
        setup(1'b1, 3'd7, 2'd3);
        write_duty(8'd4);
        en = 1'b1;
        sync_ovf();
        measure(per, hi);
        check(hi == 4, "R8 initial duty", hi, 4);
        duty_we = 1'b1; duty_wdata = 8'd12;
        measure(per, hi);
        check(hi == 4, "R8 write held until wrap", hi, 4);
        measure(per, hi);
        check(hi == 12, "R8 new duty after wrap", hi, 12);
    endtask

    task automatic t_disable();
        int bad = 0;
        int n = 0;
        setup(1'b1, 3'd7, 2'd3);
        write_duty(8'd9);
        en = 1'b1;
        sync_ovf();
        en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out || ovf_pulse) bad++;
        end
        check(bad == 0, "R9 outputs low while disabled", bad, 0);
        en = 1'b1;
        bad = 0;
        do begin
            @(negedge clk);
            n++;
            if (!ovf_pulse && pwm_out) bad++;
        end while (!ovf_pulse && n < 1000);
        check(n == 16, "R9 counter resumes from held value", n, 16);
        check(bad == 0, "R9 output low until next wrap", bad, 0);
    endtask

    initial begin
        t_reset();
        t_first_period();
        t_duty(1'b1, 3'd7, 2'd0, 8'd200);
        t_duty(1'b1, 3'd7, 2'd1, 8'hE5);
        t_duty(1'b1, 3'd7, 2'd2, 8'd31);
        t_duty(1'b1, 3'd6, 2'd3, 8'd1);
        t_prescale(1'b0, 3'd7);
        t_prescale(1'b0, 3'd3);
        t_prescale(1'b1, 3'd0);
        t_prescale(1'b0, 3'd0);
        t_zero_duty(2'd3, 8'h10);
        t_zero_duty(2'd0, 8'h00);
        t_shadow();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule